// File: doc/BRIEF.md
# Dual-Channel Serial ADC Sequencer with Power Management

This block sits next to a dual simultaneous-sampling 14-bit converter that has a serial output. It drives the converter's active-low chip-select and its serial clock. It reads both serial data lines in the same clock window and delivers two 14-bit results together with one strobe.

The converter's power state is set by the length of each frame. A frame that ends early, with chip-select raised partway through the clock burst, powers the converter down. Two such frames in a row power it fully down. A full-length frame started while the converter is down wakes it; that frame carries no valid data.

A four-code command port with a ready/valid handshake selects one of four actions: convert, partial power-down, full power-down, or wake. The block keeps its own copy of the converter's power state. It maps each command onto the frames that state calls for, and it holds off new commands until the power-up time has passed.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset, `adc_cs_n`=1, `adc_sclk`=1, `cmd_ready`=1, `res_valid`=0 and `pwr_state`=0.
  - The `pwr_state` encoding is: 0 active, 1 partial-down, 2 full-down, 3 powering-up.
- R2: A convert command (code 0) accepted while active runs one frame.
  - The frame holds `adc_cs_n` low for 16 falling edges of `adc_sclk`.
  - The converter presents bit k of its 16-bit word after falling edge k, MSB first.
  - The block samples on the following rising edge.
  - The bits from edges 3 to 16 form each 14-bit result, MSB first. They are delivered with a one-cycle `res_valid` and `res_dummy`=0.
- R3: `adc_sclk` idles high and toggles only while `adc_cs_n` is low. Its period is 2*DIV_HALF system clocks.
- R4: A partial power-down command (code 1) accepted while active runs one aborted frame.
  - `adc_cs_n` rises together with the rising edge that follows falling edge ABORT_EDGE, which must lie between 3 and 9.
  - `pwr_state` becomes 1 and no result strobe is produced.
- R5: A full power-down command (code 2) runs aborted frames until `pwr_state` reaches 2.
  - From active it runs two aborted frames.
  - From partial-down it runs one.
- R6: A wake command (code 3), or a convert command, accepted while partial-down or full-down runs a full 16-edge frame.
  - The frame ends with `res_valid`=1 and `res_dummy`=1.
  - In the cycle of that strobe, `pwr_state` is 3.
- R7: After a wake from partial-down, `cmd_ready` stays low for at least PU_PART system clocks after the dummy strobe. Then `pwr_state` returns to 0.
- R8: After a wake from full-down, `cmd_ready` stays low for at least PU_FULL system clocks after the dummy strobe. Then `pwr_state` returns to 0.
- R9: The following commands are accepted and cause no frame, no state change and no drop of `cmd_ready`:
  - partial power-down while partial-down;
  - partial or full power-down while full-down;
  - wake while active.
- R10: `cmd_ready` is low throughout every frame and every power-up wait. A `cmd_valid` presented while `cmd_ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | 0 convert, 1 partial down, 2 full down, 3 wake |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_sda | input | 1 | Channel A serial data |
| adc_sdb | input | 1 | Channel B serial data |
| res_valid | output | 1 | One-cycle result strobe |
| res_dummy | output | 1 | Strobed frame was a wake-up dummy |
| res_a | output | 14 | Channel A result |
| res_b | output | 14 | Channel B result |
| pwr_state | output | 2 | Tracked converter power state |

## Verification
Two functions can fall in the same cycle. The end of the first aborted frame of a full power-down can coincide with the launch of the second. Likewise, the dummy wake strobe can coincide with the start of the power-up timer. The bench provokes both by issuing full power-down from active and waking from each power-down state. It then judges the frame count, the falling-edge count at each chip-select rise, and the number of cycles from the dummy strobe to the return of ready. A command is also held on the port while a conversion frame runs, so that any acceptance would show up in the power state and the frame count.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    CMD_CONV      = 2'd0,
    CMD_PDN_PART  = 2'd1,
    CMD_PDN_FULL  = 2'd2,
    CMD_WAKE      = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_PART   = 2'd1,
    PS_FULL   = 2'd2,
    PS_WAKING = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    K_CONV  = 2'd0,
    K_ABORT = 2'd1,
    K_WAKE  = 2'd2
  } kind_e;
endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int DIV_HALF    = 2,
  parameter int FRAME_EDGES = 16,
  parameter int DATA_W      = 14,
  parameter int EW          = 5,
  parameter int LANES       = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [EW-1:0]                stop_edge,
  input  logic [LANES-1:0]             sd,
  output logic                         cs_n,
  output logic                         sclk,
  output logic                         done,
  output logic [LANES-1:0][DATA_W-1:0] data
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_LOW, PH_HIGH, PH_TAIL} phase_e;

  phase_e          phase;
  logic [DW-1:0]   div_cnt;
  logic [EW-1:0]   edges;
  logic            half_end;
  logic            sample_en;

  assign half_end  = (div_cnt == DW'(DIV_HALF - 1));
  assign sample_en = (phase == PH_LOW) && half_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      div_cnt <= '0;
      edges   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          cs_n    <= 1'b0;
          div_cnt <= '0;
          edges   <= '0;
          phase   <= PH_LEAD;
        end
      end else begin
        div_cnt <= half_end ? '0 : div_cnt + 1'b1;
        if (half_end) begin
          case (phase)
            PH_LEAD: begin
              sclk  <= 1'b0;
              edges <= EW'(1);
              phase <= PH_LOW;
            end
            PH_LOW: begin
              sclk <= 1'b1;
              if (edges == stop_edge) begin
                cs_n  <= 1'b1;
                phase <= PH_TAIL;
              end else begin
                phase <= PH_HIGH;
              end
            end
            PH_HIGH: begin
              sclk  <= 1'b0;
              edges <= edges + 1'b1;
              phase <= PH_LOW;
            end
            PH_TAIL: begin
              done  <= 1'b1;
              phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FRAME_EDGES-1:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else if (sample_en) shreg <= {shreg[FRAME_EDGES-2:0], sd[g]};
    end
    assign data[g] = shreg[DATA_W-1:0];
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int ABORT_EDGE  = 4,
  parameter int PU_PART     = 20,
  parameter int PU_FULL     = 60,
  parameter int EW          = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  output logic          cmd_ready,
  input  logic          done,
  output logic          start,
  output logic [EW-1:0] flen,
  output logic          res_valid,
  output logic          res_dummy,
  output pstate_e       pstate
);
  localparam int PU_MAX = (PU_FULL > PU_PART) ? PU_FULL : PU_PART;
  localparam int TW     = $clog2(PU_MAX + 1);

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_WAIT} ctl_e;

  ctl_e          ctl;
  kind_e         kind;
  logic          pend2;
  logic          from_full;
  logic [TW-1:0] tmr;

  logic  go, go_pend, go_full;
  kind_e go_kind;
  cmd_e  cmd;

  assign cmd       = cmd_e'(cmd_code);
  assign cmd_ready = (ctl == C_IDLE);

  always_comb begin
    go      = 1'b0;
    go_kind = K_CONV;
    go_pend = 1'b0;
    go_full = 1'b0;
    case (pstate)
      PS_ACTIVE: case (cmd)
        CMD_CONV:     go = 1'b1;
        CMD_PDN_PART: begin go = 1'b1; go_kind = K_ABORT; end
        CMD_PDN_FULL: begin go = 1'b1; go_kind = K_ABORT; go_pend = 1'b1; end
        default: ;
      endcase
      PS_PART: case (cmd)
        CMD_CONV, CMD_WAKE: begin go = 1'b1; go_kind = K_WAKE; end
        CMD_PDN_FULL:       begin go = 1'b1; go_kind = K_ABORT; end
        default: ;
      endcase
      PS_FULL: case (cmd)
        CMD_CONV, CMD_WAKE: begin go = 1'b1; go_kind = K_WAKE; go_full = 1'b1; end
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= C_IDLE;
      pstate    <= PS_ACTIVE;
      kind      <= K_CONV;
      pend2     <= 1'b0;
      from_full <= 1'b0;
      tmr       <= '0;
      start     <= 1'b0;
      flen      <= EW'(FRAME_EDGES);
      res_valid <= 1'b0;
      res_dummy <= 1'b0;
    end else begin
      start     <= 1'b0;
      res_valid <= 1'b0;
      case (ctl)
        C_IDLE: if (cmd_valid && go) begin
          ctl       <= C_RUN;
          start     <= 1'b1;
          kind      <= go_kind;
          pend2     <= go_pend;
          from_full <= go_full;
          flen      <= (go_kind == K_ABORT) ? EW'(ABORT_EDGE) : EW'(FRAME_EDGES);
        end
        C_RUN: if (done) begin
          case (kind)
            K_ABORT: begin
              pstate <= (pstate == PS_ACTIVE) ? PS_PART : PS_FULL;
              if (pend2) begin
                pend2 <= 1'b0;
                start <= 1'b1;
              end else begin
                ctl <= C_IDLE;
              end
            end
            K_WAKE: begin
              res_valid <= 1'b1;
              res_dummy <= 1'b1;
              pstate    <= PS_WAKING;
              tmr       <= from_full ? TW'(PU_FULL - 1) : TW'(PU_PART - 1);
              ctl       <= C_WAIT;
            end
            default: begin
              res_valid <= 1'b1;
              res_dummy <= 1'b0;
              ctl       <= C_IDLE;
            end
          endcase
        end
        C_WAIT: begin
          if (tmr == '0) begin
            pstate <= PS_ACTIVE;
            ctl    <= C_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: ctl <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int DIV_HALF   = 2,
  parameter int DATA_W     = 14,
  parameter int ABORT_EDGE = 4,
  parameter int PU_PART    = 20,
  parameter int PU_FULL    = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic              cmd_ready,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sda,
  input  logic              adc_sdb,
  output logic              res_valid,
  output logic              res_dummy,
  output logic [DATA_W-1:0] res_a,
  output logic [DATA_W-1:0] res_b,
  output logic [1:0]        pwr_state
);
  localparam int FRAME_EDGES = 16;
  localparam int EW          = $clog2(FRAME_EDGES + 1);

  logic                   start, done;
  logic [EW-1:0]          flen;
  logic [1:0][DATA_W-1:0] data;
  pstate_e                pstate;

  adc_frame_engine #(
    .DIV_HALF(DIV_HALF), .FRAME_EDGES(FRAME_EDGES), .DATA_W(DATA_W), .EW(EW), .LANES(2)
  ) u_eng (
    .clk(clk), .rst(rst), .start(start), .stop_edge(flen),
    .sd({adc_sdb, adc_sda}), .cs_n(adc_cs_n), .sclk(adc_sclk),
    .done(done), .data(data)
  );

  adc_pwr_seq #(
    .FRAME_EDGES(FRAME_EDGES), .ABORT_EDGE(ABORT_EDGE),
    .PU_PART(PU_PART), .PU_FULL(PU_FULL), .EW(EW)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .done(done), .start(start), .flen(flen),
    .res_valid(res_valid), .res_dummy(res_dummy), .pstate(pstate)
  );

  assign pwr_state = pstate;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a <= '0;
      res_b <= '0;
    end else if (done) begin
      res_a <= data[0];
      res_b <= data[1];
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk #(
  parameter int ABORT_EDGE = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       adc_cs_n,
  input logic       adc_sclk,
  input logic       res_valid,
  input logic       res_dummy,
  input logic [1:0] pwr_state
);
  logic       cs_q, sclk_q;
  logic [4:0] falls;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      falls  <= '0;
    end else begin
      cs_q   <= adc_cs_n;
      sclk_q <= adc_sclk;
      if (cs_q && !adc_cs_n) falls <= '0;
      else if (sclk_q && !adc_sclk) falls <= falls + 1'b1;
    end
  end

  AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && !adc_sclk) |-> !adc_cs_n); // R3
  AST_CS_RISE_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!cs_q && adc_cs_n) |-> adc_sclk); // R4
  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (rst)
    (!cs_q && adc_cs_n) |-> (falls == 5'd16 || falls == 5'(ABORT_EDGE))); // R2
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> !cmd_ready); // R10
  AST_SAMPLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_dummy) |-> (pwr_state == 2'd0)); // R2
  AST_DUMMY_WAKING: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_dummy) |-> (pwr_state == 2'd3)); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R2
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk #(.ABORT_EDGE(ABORT_EDGE)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .res_valid(res_valid), .res_dummy(res_dummy),
  .pwr_state(pwr_state)
);

// File: tb/adc_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module adc_pwr_ctrl_tb;
  localparam int DIV_HALF = 2, ABORT_EDGE = 4, PU_PART = 20, PU_FULL = 60;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic cmd_ready, adc_cs_n, adc_sclk, res_valid, res_dummy;
  logic adc_sda = 1'b0, adc_sdb = 1'b0;
  logic [13:0] res_a, res_b;
  logic [1:0] pwr_state;

  always #2 clk = ~clk;

  adc_pwr_ctrl #(.DIV_HALF(DIV_HALF), .ABORT_EDGE(ABORT_EDGE),
                 .PU_PART(PU_PART), .PU_FULL(PU_FULL)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_sda(adc_sda), .adc_sdb(adc_sdb), .res_valid(res_valid),
    .res_dummy(res_dummy), .res_a(res_a), .res_b(res_b), .pwr_state(pwr_state)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model
  logic [15:0] word_a = '0, word_b = '0;
  int fcnt = 0, frames = 0, last_edges = 0, per_err = 0, res_seen = 0;
  realtime t_fall = 0;

  always @(negedge adc_cs_n) fcnt = 0;
  always @(negedge adc_sclk) if (adc_cs_n === 1'b0) begin
    fcnt++;
    if (fcnt >= 2 && ($realtime - t_fall) != 4.0 * 2 * DIV_HALF) per_err++;
    t_fall = $realtime;
    adc_sda = word_a[16 - fcnt];
    adc_sdb = word_b[16 - fcnt];
  end
  always @(posedge adc_cs_n) if (fcnt != 0) begin
    frames++;
    last_edges = fcnt;
  end
  always @(negedge clk) if (!rst && adc_cs_n && !adc_sclk) per_err++;

  // scoreboard
  typedef struct { bit dummy; logic [13:0] a; logic [13:0] b; } item_t;
  item_t exp_q[$];
  realtime t_res = 0;

  always @(negedge clk) if (!rst && res_valid) begin
    res_seen++;
    t_res = $realtime;
    if (exp_q.size() == 0) check(1'b0, "R2 unexpected strobe", 1, 0);
    else begin
      item_t e;
      e = exp_q.pop_front();
      check(res_dummy == e.dummy, e.dummy ? "R6 dummy flag" : "R2 dummy flag", int'(res_dummy), int'(e.dummy));
      if (!e.dummy) begin
        check(res_a == e.a, "R2 channel A", int'(res_a), int'(e.a));
        check(res_b == e.b, "R2 channel B", int'(res_b), int'(e.b));
      end
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] code);
    wait_ready();
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic conv(input logic [13:0] a, input logic [13:0] b);
    item_t e;
    word_a = {2'b00, a};
    word_b = {2'b00, b};
    e.dummy = 1'b0; e.a = a; e.b = b;
    exp_q.push_back(e);
    send(2'd0);
  endtask

  task automatic wake(input logic [1:0] code, input int pu, input string req);
    item_t e;
    int f0;
    realtime t_rdy;
    f0 = frames;
    e.dummy = 1'b1; e.a = '0; e.b = '0;
    exp_q.push_back(e);
    wait_ready();
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check(pwr_state == 2'd3, "R6 state at dummy strobe", int'(pwr_state), 3);
    while (!cmd_ready) @(negedge clk);
    t_rdy = $realtime;
    check(int'((t_rdy - t_res) / 4.0) >= pu, req, int'((t_rdy - t_res) / 4.0), pu);
    check(pwr_state == 2'd0, {req, " state"}, int'(pwr_state), 0);
    check(frames == f0 + 1 && last_edges == 16, "R6 wake frame", last_edges, 16);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
    check(adc_sclk == 1'b1, "R1 sclk", int'(adc_sclk), 1);
    check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    check(pwr_state == 2'd0, "R1 state", int'(pwr_state), 0);

    conv(14'h2A5C, 14'h13A3);
    check(last_edges == 16, "R2 edge count", last_edges, 16);
    conv(14'h3FFF, 14'h0000);
    conv(14'h0001, 14'h2000);

    // R10: command held while a conversion frame runs
    word_a = 16'h1234; word_b = 16'h0F0F;
    begin
      item_t e; e.dummy = 1'b0; e.a = 14'h1234; e.b = 14'h0F0F; exp_q.push_back(e);
    end
    f0 = frames;
    wait_ready();
    cmd_valid = 1'b1; cmd_code = 2'd0;
    @(negedge clk);
    cmd_code = 2'd1;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready();
    repeat (3) @(negedge clk);
    check(pwr_state == 2'd0, "R10 held command ignored", int'(pwr_state), 0);
    check(frames == f0 + 1, "R10 frame count", frames, f0 + 1);

    // R9: wake while active
    f0 = frames; r0 = res_seen;
    send(2'd3);
    check(frames == f0 && pwr_state == 2'd0, "R9 wake while active", frames, f0);

    // R4: partial power-down
    f0 = frames; r0 = res_seen;
    send(2'd1);
    check(frames == f0 + 1, "R4 one frame", frames, f0 + 1);
    check(last_edges == ABORT_EDGE, "R4 abort edge", last_edges, ABORT_EDGE);
    check(pwr_state == 2'd1, "R4 state", int'(pwr_state), 1);
    check(res_seen == r0, "R4 no strobe", res_seen, r0);

    // R9: partial down while partial
    f0 = frames;
    send(2'd1);
    check(frames == f0 && pwr_state == 2'd1, "R9 partial while partial", frames, f0);

    wake(2'd0, PU_PART, "R7 partial wait");
    conv(14'h0ABC, 14'h3210);

    // R5: full from active
    f0 = frames;
    send(2'd2);
    check(frames == f0 + 2, "R5 two frames", frames, f0 + 2);
    check(last_edges == ABORT_EDGE, "R5 abort edge", last_edges, ABORT_EDGE);
    check(pwr_state == 2'd2, "R5 state full", int'(pwr_state), 2);

    // R9: commands while full
    f0 = frames;
    send(2'd2);
    send(2'd1);
    check(frames == f0 && pwr_state == 2'd2, "R9 down while full", frames, f0);

    wake(2'd3, PU_FULL, "R8 full wait");
    conv(14'h1555, 14'h2AAA);

    // R5: full from partial
    send(2'd1);
    f0 = frames;
    send(2'd2);
    check(frames == f0 + 1, "R5 one frame from partial", frames, f0 + 1);
    check(pwr_state == 2'd2, "R5 state full from partial", int'(pwr_state), 2);
    wake(2'd0, PU_FULL, "R8 wake by convert");

    repeat (10) @(negedge clk);
    check(per_err == 0, "R3 sclk period and framing", per_err, 0);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule